// File: doc/BRIEF.md
# SPI Master Transfer Engine with Loopback

This block is the serial side of a standard single-lane SPI master. It accepts 8-bit words from a ready/valid handshake, sends each one on MOSI under a clock that it generates, and delivers each word received on MISO as a one-cycle valid pulse. Static control inputs select the SCK idle level, the sampling phase and the bit order. They also enable the block, hold back new transfers, route the transmitted bit back to the receiver in place of MISO, and choose whether the slave-select lines come from the engine or from a software value.

SCK runs at a fixed fraction of the system clock. Each half period of SCK lasts `HALF_DIV` system clocks. When another word is waiting at the end of a word, the engine sends it straight after with no idle gap, and the select lines stay asserted. When the block is disabled, the output-enable signals for SCK, MOSI and the selects are low, so the pads float.

Top module: `spi_xfer_master`

## Requirements
- R1: While no transfer is running, `sck_o` equals `cfg_cpol`: low for 0 and high for 1.
- R2: With `cfg_lsb_first`=0, bit 7 of the word travels first and bit 0 last. With `cfg_lsb_first`=1 the order is reversed. The same order applies to received bits.
- R3: While `cfg_inhibit` is 1, `tx_ready` stays 0 and no transfer begins, even when `tx_valid` is 1. SCK and the selects stay idle.
- R4: When `cfg_enable`=1 and `cfg_inhibit`=0, an idle engine accepts a word in the first cycle that `tx_valid` is high. A word offered by the end of the current word is sent next without releasing the selects.
- R5: `sck_oe`, `mosi_oe` and `ss_oe` equal the value `cfg_enable` had one cycle earlier. They are 0 after reset.
- R6: With `cfg_manual_ss`=1 and `cfg_enable`=1, `ss_n_o` equals the value `ss_value` had one cycle earlier.
- R7: In automatic mode `ss_n_o` is all ones when idle and equals `ss_value` during a burst (select lines are active low). It goes active `HALF_DIV` clocks before the first SCK edge and returns to all ones `HALF_DIV` clocks after the last SCK edge.
- R8: With `cfg_loopback`=1, the received word equals the transmitted word and MISO has no effect.
- R9: With `cfg_cpha`=0, data is sampled on the odd SCK edges (the first edge of each bit) and MOSI changes on the even edges. With `cfg_cpha`=1, MOSI changes on the odd edges and data is sampled on the even edges.
- R10: Consecutive SCK edges within a burst are exactly `HALF_DIV` system clocks apart.
- R11: Each completed word raises `rx_valid` for exactly one cycle, with the 8 received bits on `rx_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enables the engine and its output drivers |
| cfg_inhibit | input | 1 | Blocks the start of new words |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Sampling phase select |
| cfg_lsb_first | input | 1 | Bit order: 1 sends bit 0 first |
| cfg_loopback | input | 1 | Feeds MOSI into the receiver in place of MISO |
| cfg_manual_ss | input | 1 | Drives the selects from `ss_value` |
| ss_value | input | NSS | Active-low select pattern |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | DW | Transmit word |
| tx_ready | output | 1 | Engine takes the word this cycle |
| rx_valid | output | 1 | One-cycle pulse per received word |
| rx_data | output | DW | Received word |
| sck_o | output | 1 | Serial clock |
| sck_oe | output | 1 | SCK output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | NSS | Slave selects, active low |
| ss_oe | output | 1 | Select output enable |

## Verification
The assertions assume that `cfg_cpol`, `cfg_cpha`, `cfg_lsb_first`, `cfg_loopback`, `cfg_manual_ss` and `ss_value` stay constant while a burst is running. They also assume that `cfg_enable` is not dropped in the middle of a word. The stimulus changes these inputs only after the selects have been released and the expected-word queue has drained. Within a burst, the only inputs that move are `tx_valid` and `tx_data`. The slave model in the bench answers with words that differ from the transmitted ones, so loopback and bit order are checked against data the engine could not produce by chance.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_TRAIL = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/spi_half_timer.sv
// Counts system clocks within one half period of SCK.
module spi_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // Two half-period boundaries are never back to back
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R10
endmodule

// File: rtl/spi_shift_unit.sv
// Serialiser and deserialiser: drives MOSI and assembles the received word.
module spi_shift_unit #(
  parameter int DW = 8,
  localparam int EW = $clog2(2*DW + 1),
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          cpha,
  input  logic          lsb_first,
  input  logic          loopback,
  input  logic          miso,
  input  logic          edge_stb,
  input  logic [EW-1:0] edge_idx,
  output logic          mosi,
  output logic          word_done,
  output logic [DW-1:0] rx_next
);
  logic [DW-1:0] tx_word;
  logic [DW-1:0] rx_acc;
  logic          mosi_r;
  logic          odd_edge, last_edge, shift_now, sample_now, din;
  logic [IW-1:0] out_seq, in_seq, out_pos, in_pos, first_pos;

  function automatic logic [IW-1:0] seq_pos(input logic [IW-1:0] seq, input logic lsb);
    return lsb ? seq : (IW'(DW - 1) - seq);
  endfunction

  assign odd_edge   = edge_idx[0];
  assign last_edge  = (edge_idx == EW'(2*DW));
  assign shift_now  = edge_stb && (cpha ? odd_edge : (!odd_edge && !last_edge));
  assign sample_now = edge_stb && (cpha ? !odd_edge : odd_edge);
  assign out_seq    = IW'(edge_idx >> 1);
  assign in_seq     = cpha ? IW'((edge_idx >> 1) - 1'b1) : IW'(edge_idx >> 1);
  assign out_pos    = seq_pos(out_seq, lsb_first);
  assign in_pos     = seq_pos(in_seq, lsb_first);
  assign first_pos  = seq_pos('0, lsb_first);
  assign din        = loopback ? mosi_r : miso;
  assign word_done  = edge_stb && last_edge;
  assign mosi       = mosi_r;

  always_comb begin
    rx_next = rx_acc;
    if (sample_now) rx_next[in_pos] = din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_word <= '0;
      rx_acc  <= '0;
      mosi_r  <= 1'b0;
    end else begin
      rx_acc <= load ? '0 : rx_next;
      if (load) begin
        tx_word <= load_word;
        if (!cpha) mosi_r <= load_word[first_pos];
      end else if (shift_now) begin
        mosi_r <= tx_word[out_pos];
      end
    end
  end

  // In phase 0 the first bit is already on MOSI before the first edge
  AST_FIRST_BIT_EARLY: assert property (@(posedge clk) disable iff (rst)
    (load && !cpha && !lsb_first) |=> (mosi == $past(load_word[DW-1]))); // R2
  AST_LOOP_ECHO: assert property (@(posedge clk) disable iff (rst)
    (loopback && sample_now) |-> (rx_next[in_pos] == mosi)); // R8
endmodule

// File: rtl/spi_ss_ctrl.sv
// Slave-select and output-enable registers.
module spi_ss_ctrl #(
  parameter int NSS = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           enable,
  input  logic           manual,
  input  logic           busy_next,
  input  logic [NSS-1:0] ss_value,
  output logic [NSS-1:0] ss_n,
  output logic           sck_oe,
  output logic           mosi_oe,
  output logic           ss_oe
);
  logic [NSS-1:0] ss_n_r;
  logic           oe_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_n_r <= '1;
      oe_r   <= 1'b0;
    end else begin
      oe_r <= enable;
      if (enable && manual) ss_n_r <= ss_value;
      else if (busy_next)   ss_n_r <= ss_value;
      else                  ss_n_r <= '1;
    end
  end

  assign ss_n    = ss_n_r;
  assign sck_oe  = oe_r;
  assign mosi_oe = oe_r;
  assign ss_oe   = oe_r;

  AST_MANUAL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (enable && manual) |=> (ss_n == $past(ss_value))); // R6
  AST_PADS_FLOAT: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sck_oe && !mosi_oe && !ss_oe)); // R5
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master
  import spi_xfer_pkg::*;
#(
  parameter int DW       = 8,
  parameter int NSS      = 2,
  parameter int HALF_DIV = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_enable,
  input  logic           cfg_inhibit,
  input  logic           cfg_cpol,
  input  logic           cfg_cpha,
  input  logic           cfg_lsb_first,
  input  logic           cfg_loopback,
  input  logic           cfg_manual_ss,
  input  logic [NSS-1:0] ss_value,
  input  logic           tx_valid,
  input  logic [DW-1:0]  tx_data,
  output logic           tx_ready,
  output logic           rx_valid,
  output logic [DW-1:0]  rx_data,
  output logic           sck_o,
  output logic           sck_oe,
  output logic           mosi_o,
  output logic           mosi_oe,
  input  logic           miso_i,
  output logic [NSS-1:0] ss_n_o,
  output logic           ss_oe
);
  localparam int EW = $clog2(2*DW + 1);
  localparam logic [EW-1:0] LAST_EDGE = EW'(2*DW - 1);

  xfer_state_t   state_q, state_n;
  logic [EW-1:0] ecnt_q, ecnt_n;
  logic          tick, can_go, accept, edge_stb, word_done, sck_r, rx_valid_r;
  logic [DW-1:0] rx_next, rx_data_r;

  assign can_go   = cfg_enable && !cfg_inhibit;
  assign tx_ready = can_go && ((state_q == ST_IDLE) ||
                    (state_q == ST_XFER && tick && ecnt_q == LAST_EDGE));
  assign accept   = tx_ready && tx_valid;
  assign edge_stb = (state_q == ST_XFER) && tick;

  spi_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk (clk),
    .rst (rst),
    .run (state_q != ST_IDLE),
    .tick(tick)
  );

  always_comb begin
    state_n = state_q;
    ecnt_n  = ecnt_q;
    if (!cfg_enable) begin
      state_n = ST_IDLE;
      ecnt_n  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_n = ST_XFER;
          ecnt_n  = '0;
        end
        ST_XFER: if (tick) begin
          if (ecnt_q == LAST_EDGE) begin
            ecnt_n  = '0;
            state_n = accept ? ST_XFER : ST_TRAIL;
          end else begin
            ecnt_n = ecnt_q + 1'b1;
          end
        end
        ST_TRAIL: if (tick) state_n = ST_IDLE;
        default:  state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      ecnt_q     <= '0;
      sck_r      <= 1'b0;
      rx_valid_r <= 1'b0;
      rx_data_r  <= '0;
    end else begin
      state_q    <= state_n;
      ecnt_q     <= ecnt_n;
      rx_valid_r <= word_done;
      if (word_done) rx_data_r <= rx_next;
      if (!cfg_enable || state_q == ST_IDLE) sck_r <= cfg_cpol;
      else if (edge_stb)                     sck_r <= ~sck_r;
    end
  end

  spi_shift_unit #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_word(tx_data),
    .cpha     (cfg_cpha),
    .lsb_first(cfg_lsb_first),
    .loopback (cfg_loopback),
    .miso     (miso_i),
    .edge_stb (edge_stb),
    .edge_idx (ecnt_q + 1'b1),
    .mosi     (mosi_o),
    .word_done(word_done),
    .rx_next  (rx_next)
  );

  spi_ss_ctrl #(.NSS(NSS)) u_ss (
    .clk      (clk),
    .rst      (rst),
    .enable   (cfg_enable),
    .manual   (cfg_manual_ss),
    .busy_next(state_n != ST_IDLE),
    .ss_value (ss_value),
    .ss_n     (ss_n_o),
    .sck_oe   (sck_oe),
    .mosi_oe  (mosi_oe),
    .ss_oe    (ss_oe)
  );

  assign sck_o    = sck_r;
  assign rx_valid = rx_valid_r;
  assign rx_data  = rx_data_r;

  AST_SCK_AT_REST: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |=> (sck_o == $past(cfg_cpol))); // R1
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && cfg_inhibit) |=> (state_q == ST_IDLE)); // R3
  AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R11
  AST_SS_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (!cfg_manual_ss && !$past(cfg_manual_ss) && state_q == ST_IDLE &&
     $past(state_q) == ST_IDLE) |-> (ss_n_o == '1)); // R7
  AST_SCK_STILL_IN_GAP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XFER && !tick && cfg_enable) |=> $stable(sck_o)); // R10
endmodule

// File: tb/spi_xfer_master_test.sv
`timescale 1ns/1ps
module spi_xfer_master_test;
  localparam int DW = 8;
  localparam int NSS = 2;
  localparam int HALF_DIV = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 0, cfg_inhibit = 0, cfg_cpol = 0, cfg_cpha = 0;
  logic cfg_lsb_first = 0, cfg_loopback = 0, cfg_manual_ss = 0;
  logic [NSS-1:0] ss_value = 2'b10;
  logic tx_valid = 0;
  logic [DW-1:0] tx_data = '0;
  logic tx_ready, rx_valid, sck_o, sck_oe, mosi_o, mosi_oe, ss_oe;
  logic miso_i = 1'b0;
  logic [DW-1:0] rx_data;
  logic [NSS-1:0] ss_n_o;

  always #5 clk = ~clk;

  spi_xfer_master #(.DW(DW), .NSS(NSS), .HALF_DIV(HALF_DIV)) uut (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_inhibit(cfg_inhibit),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_loopback(cfg_loopback), .cfg_manual_ss(cfg_manual_ss), .ss_value(ss_value),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .ss_n_o(ss_n_o), .ss_oe(ss_oe));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] exp_rx_q[$];
  logic [DW-1:0] exp_mosi_q[$];
  int nd = 0;
  bit slave_on = 1;
  int ss_rises = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] resp(input int n);
    return 8'h3C + 8'(n * 29);
  endfunction

  function automatic int bpos(input int sb, input logic lsb);
    return lsb ? sb : DW - 1 - sb;
  endfunction

  // Driver: pushes expectations, then offers the word until taken
  task automatic send(input logic [DW-1:0] d);
    exp_mosi_q.push_back(d);
    exp_rx_q.push_back(cfg_loopback ? d : resp(nd));
    nd++;
    tx_data  = d;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_rx_q.size() != 0 || ss_n_o[0] !== 1'b1) @(negedge clk);
    repeat (3*HALF_DIV + 4) @(negedge clk);
  endtask

  // Monitor: pops expected received words
  logic prev_rxv = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        if (exp_rx_q.size() == 0) chk(0, "R11 unexpected rx", 32'(rx_data), 0);
        else begin
          logic [DW-1:0] e;
          e = exp_rx_q.pop_front();
          chk(rx_data == e, "R8/R9 rx word", 32'(rx_data), 32'(e));
        end
      end
      if (rx_valid && prev_rxv) chk(0, "R11 pulse width", 2, 1);
      prev_rxv = rx_valid;
    end
  end

  // Slave model: checks edge spacing and captures MOSI
  logic prev_sck = 0, prev_ss = 1;
  int gap = 0, sb = 0, ns = 0;
  logic [DW-1:0] w = '0, cap = '0;
  always @(negedge clk) begin
    if (rst || !slave_on) begin
      prev_sck = sck_o; prev_ss = 1'b1; sb = 0; gap = 0;
    end else begin
      gap++;
      if (prev_ss && !ss_n_o[0]) begin
        sb = 0; w = resp(ns); gap = 0;
        if (!cfg_cpha) miso_i = w[bpos(0, cfg_lsb_first)];
      end else if (!prev_ss && ss_n_o[0]) begin
        ss_rises++;
        chk(gap == HALF_DIV, "R7 release delay", gap, HALF_DIV);
      end
      if (!ss_n_o[0] && sck_o != prev_sck) begin
        logic leading;
        chk(gap == HALF_DIV, "R10 edge spacing", gap, HALF_DIV);
        gap = 0;
        leading = (sck_o != cfg_cpol);
        if (leading ^ cfg_cpha) begin
          cap[bpos(sb, cfg_lsb_first)] = mosi_o;
          sb++;
          if (sb == DW) begin
            logic [DW-1:0] e;
            e = (exp_mosi_q.size() != 0) ? exp_mosi_q.pop_front() : ~cap;
            chk(cap == e, "R2/R9 mosi word", 32'(cap), 32'(e));
            ns++; sb = 0; w = resp(ns);
          end
        end else begin
          miso_i = w[bpos(sb, cfg_lsb_first)];
        end
      end
      prev_sck = sck_o; prev_ss = ss_n_o[0];
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state
    chk(!sck_oe && !mosi_oe && !ss_oe, "R5 reset oe", {sck_oe, mosi_oe, ss_oe}, 0);
    chk(ss_n_o == '1, "R7 reset ss", ss_n_o, 2'b11);
    chk(!rx_valid, "R11 reset rx_valid", rx_valid, 0);
    chk(!tx_ready, "R4 ready while off", tx_ready, 0);

    cfg_enable = 1; cfg_cpol = 0;
    repeat (2) @(negedge clk);
    chk(sck_oe && mosi_oe && ss_oe, "R5 oe on", {sck_oe, mosi_oe, ss_oe}, 3'b111);
    chk(sck_o == 1'b0, "R1 idle low", sck_o, 0);
    cfg_cpol = 1;
    repeat (2) @(negedge clk);
    chk(sck_o == 1'b1, "R1 idle high", sck_o, 1);

    // All modes, bit orders, two words per burst (R2, R4, R9, R10)
    for (int m = 0; m < 8; m++) begin
      int r0;
      cfg_cpol = m[0]; cfg_cpha = m[1]; cfg_lsb_first = m[2];
      repeat (3) @(negedge clk);
      chk(sck_o == cfg_cpol, "R1 idle level", sck_o, cfg_cpol);
      r0 = ss_rises;
      send(8'hC1 ^ 8'(m * 37));
      send(8'h5A + 8'(m));
      wait_done();
      chk(ss_rises == r0 + 1, "R4 burst kept select", ss_rises - r0, 1);
    end

    // Loopback ignores MISO (R8)
    cfg_loopback = 1;
    for (int m = 0; m < 4; m++) begin
      cfg_cpol = m[0]; cfg_cpha = m[1]; cfg_lsb_first = ~m[0];
      repeat (3) @(negedge clk);
      send(8'h96 ^ 8'(m * 11));
      wait_done();
    end
    cfg_loopback = 0;

    // Inhibit blocks starts (R3)
    begin
      bit quiet = 1;
      cfg_inhibit = 1; cfg_cpol = 0; cfg_cpha = 0;
      tx_data = 8'hE7; tx_valid = 1;
      repeat (40) begin
        @(negedge clk);
        if (tx_ready || ss_n_o != '1 || sck_o != cfg_cpol || rx_valid) quiet = 0;
      end
      tx_valid = 0;
      chk(quiet, "R3 inhibit held", quiet, 1);
      cfg_inhibit = 0;
      @(negedge clk);
      chk(tx_ready, "R4 ready after inhibit", tx_ready, 1);
      send(8'hE7);
      wait_done();
    end

    // Manual select (R6)
    slave_on = 0;
    cfg_manual_ss = 1; ss_value = 2'b01;
    @(negedge clk);
    chk(ss_n_o == 2'b01, "R6 manual 01", ss_n_o, 2'b01);
    ss_value = 2'b00;
    @(negedge clk);
    chk(ss_n_o == 2'b00, "R6 manual 00", ss_n_o, 2'b00);
    cfg_manual_ss = 0; ss_value = 2'b10;
    repeat (2) @(negedge clk);
    chk(ss_n_o == 2'b11, "R7 auto idle", ss_n_o, 2'b11);

    // Disabled: pads float, nothing starts (R5)
    cfg_enable = 0;
    @(negedge clk);
    chk(!sck_oe && !mosi_oe && !ss_oe, "R5 oe off", {sck_oe, mosi_oe, ss_oe}, 0);
    tx_valid = 1; tx_data = 8'h11;
    begin
      bit still = 1;
      repeat (20) begin
        @(negedge clk);
        if (tx_ready || rx_valid || ss_n_o != '1) still = 0;
      end
      chk(still, "R5 disabled idle", still, 1);
    end
    tx_valid = 0;
    repeat (5) @(negedge clk);
    chk(exp_rx_q.size() == 0 && exp_mosi_q.size() == 0, "R11 all words seen",
        exp_rx_q.size() + exp_mosi_q.size(), 0);
    finish_run();
  end
endmodule